// File: doc/BRIEF.md
# I2C Master SCL Bit-Rate Generator

This block sets the timing of the serial clock for an I2C master. A small prescaler divides the peripheral clock by a 3-bit code to produce a tick enable. Each SCL period is then built from two phases measured in ticks. In the low phase the block asks the pad to pull SCL down. In the high phase it lets the line go and waits for it to rise. Both phase lengths come from one 16-bit divider word. The high count sits in the upper byte and the low count in the lower byte.

The low phase lasts one tick more than its programmed count. The high phase lasts two ticks more than its programmed count. A full period therefore takes LOW + HIGH + 3 ticks. With a divide of 1, HIGH = 0x62 and LOW = 0x63, the period is 200 clocks, which gives 100 kHz from 20 MHz. The high-phase count pauses on any tick where the sampled SCL level is still low, so a slave that stretches the clock lengthens the high phase by the stretched ticks.

The bit engine uses two one-cycle strobes: one marks the release of SCL and one marks the start of the pull. Deasserting the enable clears all counting and releases the line. The prescale code and the divider word are expected to stay unchanged while the block is enabled.

Top module: `scl_rate_gen`

## Requirements
- R1: During reset, and after reset while `enable` is low, `scl_pull_low`, `rise_tick` and `fall_tick` are all 0.
- R2: While enabled, the prescaler emits one tick every P clocks, where P is the value of `prescale[2:0]`. A code of 0 behaves as 1. `scl_pull_low` changes only on the clock edge of a tick. After enable rises, the first tick (and so the first `fall_tick`) comes on the P-th rising clock edge.
- R3: The low phase lasts LOW+1 ticks, with LOW = `divider[7:0]`. It is measured from the edge that sets `scl_pull_low` to the edge that clears it.
- R4: When the sampled line is high throughout, the high phase lasts HIGH+2 ticks, with HIGH = `divider[15:8]`.
- R5: A period without stretching is LOW+HIGH+3 ticks. With P=1, HIGH=0x62 and LOW=0x63, one period is 200 clocks.
- R6: During the high phase, a tick on which `scl_sense` is 0 does not advance the high-phase count. Each such tick lengthens the high phase by one tick.
- R7: When `enable` is low at a rising edge, `scl_pull_low` is 0 and both strobes are 0 after that edge. The period restarts from the beginning on the next enable.
- R8: `fall_tick` is 1 for exactly the one cycle in which `scl_pull_low` has just gone from 0 to 1. `rise_tick` is 1 for exactly the one cycle in which it has just gone from 1 to 0. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| enable | input | 1 | Runs the generator when high; clears and releases when low |
| prescale | input | 3 | Clock divide code P (0 acts as 1) |
| divider | input | 16 | [15:8] high count, [7:0] low count |
| scl_sense | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | Request to drive SCL low |
| rise_tick | output | 1 | One-cycle strobe at SCL release |
| fall_tick | output | 1 | One-cycle strobe at SCL pull |

## Verification
A wrong phase count shows on `scl_pull_low` as an edge that comes early or late. This appears in the first period after enable, at most LOW+HIGH+3 ticks later. A prescaler fault moves every `scl_pull_low` edge off the tick grid starting from the very first tick. A stretch hold that leaks into the count ends the high phase early, in the same period as the stretch. A strobe that is out of step with the pull request shows up on the same clock as the transition it should mark. The cycle model in the bench therefore catches each such fault within one SCL period.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // clocks per tick for a prescale code; code 0 acts as 1
  function automatic int unsigned tick_ratio(input int unsigned pre_code);
    return (pre_code == 0) ? 1 : pre_code;
  endfunction

  // timer value loaded at high-phase entry: phase spans high_code+2 ticks
  function automatic int unsigned high_reload(input int unsigned high_code);
    return high_code + 1;
  endfunction

  // timer value loaded at low-phase entry: phase spans low_code+1 ticks
  function automatic int unsigned low_reload(input int unsigned low_code);
    return low_code;
  endfunction

  // ticks per unstretched period
  function automatic int unsigned period_ticks(input int unsigned low_code,
                                               input int unsigned high_code);
    return low_code + high_code + 3;
  endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale
  import scl_rate_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_code,
  output logic             ce
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(tick_ratio(32'(pre_code)) - 32'd1);
  assign ce    = en && (pcnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      pcnt <= '0;
    else if (!en)    pcnt <= '0;
    else if (ce)     pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

  // R2: with a divide above 1 and a steady code, ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && $past(en) && $stable(pre_code) && (pre_code > 1)) |-> !$past(ce));

  // R2: with divide 1 every enabled clock is a tick
  a_r2_divide_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (pre_code <= 1)) |-> ce);

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int TMR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (dec)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3: the controller never asks for a decrement past zero
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt != '0));

  // R6: with no load, clear or decrement the count is frozen
  a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !dec) |=> $stable(cnt));

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_rate_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int TMR_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ce,
  input  logic             scl_sense,
  input  logic [CNT_W-1:0] low_code,
  input  logic [CNT_W-1:0] high_code,
  input  logic             tmr_zero,
  output logic             tmr_clr,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             tmr_dec,
  output logic             ev_to_low,
  output logic             ev_hold,
  output logic             pull_low,
  output logic             rise_tick,
  output logic             fall_tick
);

  scl_phase_e phase, nxt;
  logic       ev_to_high;

  always_comb begin
    nxt        = phase;
    ev_to_low  = 1'b0;
    ev_to_high = 1'b0;
    ev_hold    = 1'b0;
    tmr_dec    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (ce) begin
          nxt       = PH_LOW;
          ev_to_low = 1'b1;
        end
      end
      PH_LOW: begin
        if (ce) begin
          if (tmr_zero) begin
            nxt        = PH_HIGH;
            ev_to_high = 1'b1;
          end else begin
            tmr_dec = 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (ce) begin
          if (!scl_sense) begin
            ev_hold = 1'b1;
          end else if (tmr_zero) begin
            nxt       = PH_LOW;
            ev_to_low = 1'b1;
          end else begin
            tmr_dec = 1'b1;
          end
        end
      end
      default: nxt = PH_IDLE;
    endcase
    if (!en) nxt = PH_IDLE;
  end

  assign tmr_clr  = !en;
  assign tmr_load = ev_to_low || ev_to_high;
  assign tmr_val  = ev_to_high ? TMR_W'(high_reload(32'(high_code)))
                               : TMR_W'(low_reload(32'(low_code)));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase     <= PH_IDLE;
      pull_low  <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      phase     <= nxt;
      rise_tick <= ev_to_high;
      fall_tick <= ev_to_low;
      if (ev_to_low)       pull_low <= 1'b1;
      else if (ev_to_high) pull_low <= 1'b0;
    end
  end

  // R8: the two strobes are exclusive
  a_r8_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));

  // R8: release strobe lines up with the pull request falling
  a_r8_rise_marks_release: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (!pull_low && $past(pull_low)));

  // R8: pull strobe lines up with the pull request rising
  a_r8_fall_marks_pull: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (pull_low && !$past(pull_low)));

  // R6: a held tick keeps the block in the released high phase
  a_r6_hold_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> (phase == PH_HIGH && !pull_low));

  // R7: disabling releases the line and returns to idle
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pull_low && !rise_tick && !fall_tick && phase == PH_IDLE));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int CNT_W = 8,
  localparam int DIV_W = 2 * CNT_W,
  localparam int TMR_W = CNT_W + 1,
  localparam int PER_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] divider,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [CNT_W-1:0] low_code;
  logic [CNT_W-1:0] high_code;
  logic             ce;
  logic             tmr_clr, tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             ev_to_low, ev_hold;

  assign low_code  = divider[CNT_W-1:0];
  assign high_code = divider[DIV_W-1:CNT_W];

  scl_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .pre_code (prescale),
    .ce       (ce)
  );

  scl_phase_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  scl_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .ce        (ce),
    .scl_sense (scl_sense),
    .low_code  (low_code),
    .high_code (high_code),
    .tmr_zero  (tmr_zero),
    .tmr_clr   (tmr_clr),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_dec   (tmr_dec),
    .ev_to_low (ev_to_low),
    .ev_hold   (ev_hold),
    .pull_low  (scl_pull_low),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  // period observer: ticks since the last pull, for the period assertion
  logic [PER_W-1:0] ticks_since;
  logic             armed;
  logic             stretched;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      ticks_since <= '0;
      armed       <= 1'b0;
      stretched   <= 1'b0;
    end else if (ce) begin
      if (ev_to_low) begin
        ticks_since <= '0;
        armed       <= 1'b1;
        stretched   <= 1'b0;
      end else begin
        ticks_since <= ticks_since + 1'b1;
        if (ev_hold) stretched <= 1'b1;
      end
    end
  end

  // R5: an unstretched period spans low + high + 3 ticks
  a_r5_period: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_to_low && armed && !stretched) |->
      ((32'(ticks_since) + 32'd1) == period_ticks(32'(low_code), 32'(high_code))));

  // R2: the pull request moves only on tick edges while running
  a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (scl_pull_low != $past(scl_pull_low))) |-> $past(ce));

endmodule

// File: tb/test_scl_rate_gen.sv
`timescale 1ns/1ps
module test_scl_rate_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  prescale = 3'd0;
  logic [15:0] divider = 16'd0;
  logic        stretch = 1'b0;
  logic        scl_pull_low, rise_tick, fall_tick;
  wire         scl_sense = ~scl_pull_low & ~stretch;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  scl_rate_gen i_scl_rate_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .prescale     (prescale),
    .divider      (divider),
    .scl_sense    (scl_sense),
    .scl_pull_low (scl_pull_low),
    .rise_tick    (rise_tick),
    .fall_tick    (fall_tick)
  );

  // behavioural reference: phase = 0 idle, 1 low, 2 high; rem = ticks left
  int m_phase = 0, m_rem = 0, m_clk = 0;
  bit m_drv = 0, m_rise = 0, m_fall = 0;

  always @(posedge clk) begin
    int n;
    int lo_v;
    int hi_v;
    if (!rst_n || !enable) begin
      m_phase = 0; m_rem = 0; m_clk = 0;
      m_drv = 0; m_rise = 0; m_fall = 0;
    end else begin
      n    = (prescale == 0) ? 1 : int'(prescale);
      lo_v = int'(divider[7:0]);
      hi_v = int'(divider[15:8]);
      m_rise = 0; m_fall = 0;
      if ((m_clk % n) == n - 1) begin
        if (m_phase == 0) begin
          m_phase = 1; m_rem = lo_v + 1; m_drv = 1; m_fall = 1;
        end else if (m_phase == 1) begin
          m_rem--;
          if (m_rem == 0) begin
            m_phase = 2; m_rem = hi_v + 2; m_drv = 0; m_rise = 1;
          end
        end else if (scl_sense) begin
          m_rem--;
          if (m_rem == 0) begin
            m_phase = 1; m_rem = lo_v + 1; m_drv = 1; m_fall = 1;
          end
        end
      end
      m_clk++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (scl_pull_low !== m_drv) begin
        bad++;
        $display("FAIL R3/R4 pull_low actual=%0d expected=%0d at cycle %0d", scl_pull_low, m_drv, cyc);
      end
      total++;
      if (rise_tick !== m_rise || fall_tick !== m_fall) begin
        bad++;
        $display("FAIL R8 strobes rise/fall actual=%0d/%0d expected=%0d/%0d at cycle %0d",
                 rise_tick, fall_tick, m_rise, m_fall, cyc);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] p, input logic [15:0] d);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    prescale = p;
    divider  = d;
    enable   = 1'b1;
  endtask

  task automatic measure(output int lo, output int hi);
    int c;
    do @(negedge clk); while (!fall_tick);
    c = 0;
    do begin @(negedge clk); c++; end while (!rise_tick);
    lo = c;
    c = 0;
    do begin @(negedge clk); c++; end while (!fall_tick);
    hi = c;
  endtask

  task automatic stretched_high(input int s, output int hi);
    int c;
    do @(negedge clk); while (!rise_tick);
    stretch = 1'b1;
    repeat (s) @(negedge clk);
    stretch = 1'b0;
    c = s;
    while (!fall_tick) begin @(negedge clk); c++; end
    hi = c;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lo, hi, c;
    repeat (3) @(negedge clk);
    chk("R1 pull_low in reset", int'(scl_pull_low), 0);
    chk("R1 strobes in reset", int'(rise_tick | fall_tick), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pull_low idle after reset", int'(scl_pull_low), 0);

    // 100 kHz setting at divide 1
    start(3'd1, 16'h6263);
    measure(lo, hi);
    chk("R3 low clocks 0x63", lo, 100);
    chk("R4 high clocks 0x62", hi, 100);
    chk("R5 period clocks", lo + hi, 200);

    // code 0 behaves as divide 1
    start(3'd0, 16'h0305);
    measure(lo, hi);
    chk("R2 zero code low", lo, 6);
    chk("R2 zero code high", hi, 5);

    start(3'd5, 16'h0201);
    measure(lo, hi);
    chk("R3 low at divide 5", lo, 10);
    chk("R4 high at divide 5", hi, 20);

    start(3'd7, 16'h0000);
    measure(lo, hi);
    chk("R2 divide 7 low", lo, 7);
    chk("R5 divide 7 period", lo + hi, 21);

    start(3'd2, 16'h00FF);
    measure(lo, hi);
    chk("R3 low 0xFF at divide 2", lo, 512);
    chk("R4 high 0x00 at divide 2", hi, 4);

    // clock stretching
    start(3'd1, 16'h0403);
    measure(lo, hi);
    chk("R4 unstretched high", hi, 6);
    stretched_high(5, hi);
    chk("R6 stretched high", hi, 11);

    start(3'd3, 16'h0202);
    stretched_high(4, hi);
    measure(lo, hi);
    chk("R6 period after stretch low", lo, 9);

    // disable in mid-low, then restart
    do @(negedge clk); while (!fall_tick);
    @(negedge clk);
    chk("R7 pulled before disable", int'(scl_pull_low), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R7 released after disable", int'(scl_pull_low), 0);
    repeat (3) begin
      @(negedge clk);
      chk("R7 quiet while disabled", int'(scl_pull_low | rise_tick | fall_tick), 0);
    end
    prescale = 3'd3;
    divider  = 16'h0101;
    enable   = 1'b1;
    c = 0;
    do begin @(negedge clk); c++; end while (!fall_tick);
    chk("R7 first pull after restart", c, 3);
    measure(lo, hi);
    chk("R2 restart low", lo, 6);
    chk("R2 restart high", hi, 9);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule